// File: doc/BRIEF.md
# HDLC Receive Frame Status Counter

This block follows each received HDLC frame once address filtering has accepted it. It counts the payload bytes of the frame and compares the running count with a programmable maximum. When the closing flag arrives it captures the CRC verdict supplied by the external checker. It then emits a one-cycle status word: the total frame length, a last-in-frame marker, a too-long bit and a CRC-error bit. The length is the total for the frame, so a frame spread across several receive buffers still reports its complete size.

The block also coalesces receive interrupts. A pending counter counts completed frames. The interrupt pulses only when that count reaches a programmable threshold. An external timeout pulse flushes a partial batch so that a slow trickle of frames is still serviced. A shared flag between back-to-back frames is signalled by asserting the end and start strobes in the same cycle. Computing the CRC is outside this block; it only consumes the verdict.

Top module: `hdlc_rx_frame_stat`

## Requirements
- R1: An end strobe (`frm_end`) while a frame is open produces `st_valid` high for exactly the next cycle, with `st_last` = 1. An end strobe while no frame is open produces no status.
- R2: `st_len` equals the number of cycles with `rx_byte` = 1 and neither `frm_start` nor `frm_end` asserted, counted between the opening start strobe and the end strobe. A `rx_byte` on a start or end cycle is not counted.
- R3: `st_too_long` = 1 when the frame length is greater than `max_len`. A frame of exactly `max_len` bytes reports 0.
- R4: `st_crc_err` equals the inverse of `crc_good` as sampled in the end-strobe cycle.
- R5: `frm_start` and `frm_end` in the same cycle close the current frame and open a new one. The new frame starts at length 0 with the too-long flag clear.
- R6: `irq` pulses for one cycle, one cycle after the frame completion that brings the pending frame count up to `irq_thresh`. The pending count then returns to 0.
- R7: An `irq_thresh` of 0 or 1 raises `irq` after every completed frame.
- R8: A `tmo_pulse` raises `irq` in the next cycle and clears the pending count when at least one frame is pending or completes in that cycle. With nothing pending it raises no `irq`.
- R9: The length count saturates at 2^LEN_W-1 (65535 by default), and such a frame reports too-long for any smaller `max_len`.
- R10: During and after reset, `st_valid` and `irq` are 0 and no frame is open.
- R11: `rx_byte` pulses while no frame is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 1 | One accepted payload byte this cycle |
| frm_start | input | 1 | Opening flag seen, frame begins |
| frm_end | input | 1 | Closing flag seen, frame ends |
| crc_good | input | 1 | CRC verdict, valid with frm_end |
| max_len | input | LEN_W | Largest allowed frame length |
| irq_thresh | input | CNT_W | Frames to collect per interrupt |
| tmo_pulse | input | 1 | Timeout, flushes pending frames |
| st_valid | output | 1 | Status word valid (one cycle) |
| st_len | output | LEN_W | Total frame length |
| st_last | output | 1 | Last-in-frame marker |
| st_too_long | output | 1 | Frame exceeded max_len |
| st_crc_err | output | 1 | CRC check failed |
| irq | output | 1 | Coalesced receive interrupt |

## Verification
A wrong open/closed frame state shows up at the very next end strobe. The status either appears for a frame that never opened or is missing for one that did, one cycle after `frm_end`. A corrupted byte count or too-long flag is visible only in the status word of the frame it belongs to, so each frame length and limit case is closed with an end strobe and checked at once. A wrong pending count delays or advances `irq` by whole frames, so the bench runs several thresholds and timeout placements and checks the cycle after every completion.

// File: rtl/hdlc_rx_stat_pkg.sv
package hdlc_rx_stat_pkg;

    typedef enum logic {
        FRM_IDLE = 1'b0,
        FRM_OPEN = 1'b1
    } frm_state_e;

endpackage

// File: rtl/hdlc_rx_len_trk.sv
module hdlc_rx_len_trk
    import hdlc_rx_stat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_byte,
    input  logic             frm_start,
    input  logic             frm_end,
    input  logic             crc_good,
    input  logic [LEN_W-1:0] max_len,
    output logic             frame_done,
    output logic             st_valid,
    output logic [LEN_W-1:0] st_len,
    output logic             st_too_long,
    output logic             st_crc_err
);

    localparam logic [LEN_W-1:0] LEN_SAT = {LEN_W{1'b1}};

    typedef struct packed {
        frm_state_e       state;
        logic [LEN_W-1:0] cnt;
        logic             over;
        logic             out_vld;
        logic [LEN_W-1:0] out_len;
        logic             out_over;
        logic             out_crc_err;
    } trk_t;

    trk_t trk_d, trk_q;
    logic closing;

    always_comb begin
        trk_d = trk_q;
        trk_d.out_vld = 1'b0;
        closing = frm_end && (trk_q.state == FRM_OPEN);

        if (closing) begin
            trk_d.out_vld     = 1'b1;
            trk_d.out_len     = trk_q.cnt;
            trk_d.out_over    = trk_q.over;
            trk_d.out_crc_err = !crc_good;
            trk_d.state       = FRM_IDLE;
        end

        if (frm_start) begin
            trk_d.state = FRM_OPEN;
            trk_d.cnt   = '0;
            trk_d.over  = 1'b0;
        end else if (!frm_end && rx_byte && trk_q.state == FRM_OPEN) begin
            if (trk_q.cnt >= max_len) begin
                trk_d.over = 1'b1;
            end
            if (trk_q.cnt != LEN_SAT) begin
                trk_d.cnt = trk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign frame_done  = closing;
    assign st_valid    = trk_q.out_vld;
    assign st_len      = trk_q.out_len;
    assign st_too_long = trk_q.out_over;
    assign st_crc_err  = trk_q.out_crc_err;

endmodule

// File: rtl/hdlc_rx_irq_coal.sv
module hdlc_rx_irq_coal #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [CNT_W-1:0] irq_thresh,
    input  logic             tmo_pulse,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] pend;
        logic             irq;
    } coal_t;

    coal_t coal_d, coal_q;
    logic [CNT_W:0] pend_next;
    logic           fire;

    always_comb begin
        coal_d     = coal_q;
        coal_d.irq = 1'b0;
        pend_next  = {1'b0, coal_q.pend} + {{CNT_W{1'b0}}, frame_done};
        fire       = (frame_done && (pend_next >= {1'b0, irq_thresh}))
                   || (tmo_pulse && (pend_next != '0));
        if (fire) begin
            coal_d.irq  = 1'b1;
            coal_d.pend = '0;
        end else begin
            coal_d.pend = pend_next[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coal_q <= '0;
        end else begin
            coal_q <= coal_d;
        end
    end

    assign irq = coal_q.irq;

endmodule

// File: rtl/hdlc_rx_frame_stat.sv
module hdlc_rx_frame_stat #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_byte,
    input  logic             frm_start,
    input  logic             frm_end,
    input  logic             crc_good,
    input  logic [LEN_W-1:0] max_len,
    input  logic [CNT_W-1:0] irq_thresh,
    input  logic             tmo_pulse,
    output logic             st_valid,
    output logic [LEN_W-1:0] st_len,
    output logic             st_last,
    output logic             st_too_long,
    output logic             st_crc_err,
    output logic             irq
);

    logic frame_done;

    hdlc_rx_len_trk #(.LEN_W(LEN_W)) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_byte     (rx_byte),
        .frm_start   (frm_start),
        .frm_end     (frm_end),
        .crc_good    (crc_good),
        .max_len     (max_len),
        .frame_done  (frame_done),
        .st_valid    (st_valid),
        .st_len      (st_len),
        .st_too_long (st_too_long),
        .st_crc_err  (st_crc_err)
    );

    hdlc_rx_irq_coal #(.CNT_W(CNT_W)) u_coal (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .irq_thresh (irq_thresh),
        .tmo_pulse  (tmo_pulse),
        .irq        (irq)
    );

    // every status word closes a whole frame
    assign st_last = st_valid;

endmodule

// File: rtl/hdlc_rx_frame_stat_chk.sv
module hdlc_rx_frame_stat_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_end,
    input logic             crc_good,
    input logic             tmo_pulse,
    input logic [LEN_W-1:0] max_len,
    input logic             st_valid,
    input logic [LEN_W-1:0] st_len,
    input logic             st_last,
    input logic             st_too_long,
    input logic             st_crc_err,
    input logic             irq
);

    // R1
    status_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> ($past(frm_end) && st_last));

    // R4
    crc_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_crc_err == !$past(crc_good)));

    // R3
    len_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_too_long) |-> (st_len <= $past(max_len)));

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(frm_end) || $past(tmo_pulse)));

    // R10
    quiet_after_reset_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!st_valid && !irq));

endmodule

bind hdlc_rx_frame_stat hdlc_rx_frame_stat_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/hdlc_rx_frame_stat_test.sv
`timescale 1ns/1ps
module hdlc_rx_frame_stat_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_byte = 1'b0, frm_start = 1'b0, frm_end = 1'b0;
    logic        crc_good = 1'b1, tmo_pulse = 1'b0;
    logic [15:0] max_len = 16'd5;
    logic [7:0]  irq_thresh = 8'd2;
    logic        st_valid, st_last, st_too_long, st_crc_err, irq;
    logic [15:0] st_len;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    hdlc_rx_frame_stat uut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .frm_start(frm_start),
        .frm_end(frm_end), .crc_good(crc_good), .max_len(max_len),
        .irq_thresh(irq_thresh), .tmo_pulse(tmo_pulse), .st_valid(st_valid),
        .st_len(st_len), .st_last(st_last), .st_too_long(st_too_long),
        .st_crc_err(st_crc_err), .irq(irq)
    );

    typedef struct packed {
        logic        s, e, b, c, t;
        logic        x_vld;
        logic [15:0] x_len;
        logic        x_tl, x_ce, x_irq;
    } vec_t;

    function automatic vec_t mk(int s, int e, int b, int c, int t,
                                int v, int l, int tl, int ce, int q);
        vec_t r;
        r.s = s[0]; r.e = e[0]; r.b = b[0]; r.c = c[0]; r.t = t[0];
        r.x_vld = v[0]; r.x_len = l[15:0]; r.x_tl = tl[0];
        r.x_ce = ce[0]; r.x_irq = q[0];
        return r;
    endfunction

    // max_len = 5, irq_thresh = 2
    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        mk(1,0,0,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,1,0,1,0, 1,3,0,0,0),
        mk(1,0,0,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(1,1,0,0,0, 1,6,1,1,1),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,1,0,1,0, 1,2,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,1,0,1,0, 0,0,0,0,0),
        mk(0,0,0,1,1, 0,0,0,0,1),
        mk(0,0,0,1,1, 0,0,0,0,0),
        mk(1,0,0,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,0,1,1,0, 0,0,0,0,0),
        mk(0,1,1,1,0, 1,5,0,0,0),
        mk(1,0,1,1,0, 0,0,0,0,0),
        mk(0,1,0,1,0, 1,0,0,0,1)
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs, then sample what the design registered
    task automatic step(bit s, bit e, bit b, bit c, bit t);
        @(negedge clk);
        frm_start = s; frm_end = e; rx_byte = b; crc_good = c; tmo_pulse = t;
        @(posedge clk);
        #1;
    endtask

    task automatic frame(int n, bit c);
        step(1, 0, 0, 1, 0);
        for (int i = 0; i < n; i++) step(0, 0, 1, 1, 0);
        step(0, 1, 0, c, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R10: outputs quiet in reset
        repeat (3) @(posedge clk);
        #1;
        check("R10 st_valid in reset", int'(st_valid), 0);
        check("R10 irq in reset", int'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 / R11: no frame open after reset, bytes and end ignored
        step(0, 0, 1, 1, 0);
        step(0, 1, 0, 1, 0);
        check("R10 no frame open after reset", int'(st_valid), 0);
        check("R11 bytes outside frame", int'(irq), 0);

        for (int k = 0; k < NV; k++) begin
            step(VECS[k].s, VECS[k].e, VECS[k].b, VECS[k].c, VECS[k].t);
            check($sformatf("R1 st_valid row %0d", k), int'(st_valid), int'(VECS[k].x_vld));
            check($sformatf("R6 irq row %0d", k), int'(irq), int'(VECS[k].x_irq));
            if (VECS[k].x_vld) begin
                check($sformatf("R2 st_len row %0d", k), int'(st_len), int'(VECS[k].x_len));
                check($sformatf("R3 st_too_long row %0d", k), int'(st_too_long), int'(VECS[k].x_tl));
                check($sformatf("R4 st_crc_err row %0d", k), int'(st_crc_err), int'(VECS[k].x_ce));
                check($sformatf("R1 st_last row %0d", k), int'(st_last), 1);
            end
            if (k == 12) check("R5 shared flag closes and opens", int'(st_valid), 1);
            if (k == 15) check("R5 new frame restarted clean", int'(st_too_long), 0);
        end
        // the status pulse lasts one cycle
        step(0, 0, 0, 1, 0);
        check("R1 st_valid single cycle", int'(st_valid), 0);

        // R7: thresholds 0 and 1 fire on every frame
        irq_thresh = 8'd0;
        for (int f = 0; f < 3; f++) begin
            frame(1, 1);
            check("R7 thresh 0 irq", int'(irq), 1);
        end
        irq_thresh = 8'd1;
        for (int f = 0; f < 3; f++) begin
            frame(2, 1);
            check("R7 thresh 1 irq", int'(irq), 1);
        end

        // R6: thresh 3, irq on the third frame only, then count restarts
        irq_thresh = 8'd3;
        frame(1, 1); check("R6 thresh 3 frame 1", int'(irq), 0);
        frame(1, 1); check("R6 thresh 3 frame 2", int'(irq), 0);
        frame(1, 1); check("R6 thresh 3 frame 3", int'(irq), 1);
        step(0, 0, 0, 1, 0); check("R6 irq one cycle", int'(irq), 0);
        frame(1, 1); check("R6 count restarted", int'(irq), 0);
        frame(1, 1); check("R6 count restarted 2", int'(irq), 0);
        frame(1, 1); check("R6 fires again", int'(irq), 1);

        // R8: timeout together with a completing frame, then count is clear
        irq_thresh = 8'd4;
        frame(1, 1); check("R8 one pending", int'(irq), 0);
        step(1, 0, 0, 1, 0);
        step(0, 1, 0, 1, 1);
        check("R8 timeout with completion", int'(irq), 1);
        frame(1, 1); frame(1, 1); frame(1, 1);
        check("R8 pending cleared by timeout", int'(irq), 0);
        frame(1, 1);
        check("R8 fourth frame fires", int'(irq), 1);
        step(0, 0, 0, 1, 1);
        check("R8 timeout with none pending", int'(irq), 0);

        // R3 boundary with a different limit
        max_len = 16'd1;
        frame(1, 1); check("R3 exactly max_len", int'(st_too_long), 0);
        frame(2, 1); check("R3 one over max_len", int'(st_too_long), 1);
        check("R2 length over limit", int'(st_len), 2);

        // R9: counter saturates
        max_len = 16'd10;
        frame(65540, 0);
        check("R9 saturated length", int'(st_len), 65535);
        check("R9 too long on saturation", int'(st_too_long), 1);
        check("R4 crc error flagged", int'(st_crc_err), 1);

        // R10: reset in mid frame leaves no frame open
        step(1, 0, 0, 1, 0);
        step(0, 0, 1, 1, 0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R10 st_valid under reset", int'(st_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 1, 0, 1, 0);
        check("R10 frame dropped by reset", int'(st_valid), 0);

        summary();
        $finish;
    end

endmodule